// File: doc/BRIEF.md
# Four-Way MEI Cache Tag Directory

This block holds the tags, coherency states and replacement order for a 16 KB, four-way set-associative cache. The cache is tagged by physical address and uses 32-byte lines, so there are 128 sets. The data arrays, the bus side and the line-fill sequencing live elsewhere. The directory answers three kinds of traffic:

- **Lookups** from the load/store path. Each lookup returns hit, hit way and line state. On a miss it also returns the victim way and whether that victim must be cast out.
- **Fills**, which install a tag and state once the line has arrived.
- **Snoops** from other bus masters. A snoop that hits invalidates the line, and it requests a writeback when the line was dirty.

Lines are only ever modified, exclusive or invalid. The directory stays coherent next to peers that use a shared state by never keeping a line that another cache holds. A read fill that the bus reports as shared is not installed, and the access is treated as non-cacheable. Each hit makes its way the most recent in a per-set true-LRU order. Free ways are consumed before any valid way is evicted.

All three requests present a line address, which is the 32-bit physical address without its five offset bits. Bits [6:0] of the line address (address bits [11:5]) select the set. Bits [26:7] (address bits [31:12]) form the tag. Responses appear one clock after the request.

Top module: `mei_tag_array`

## Requirements
- R1: After reset every line is invalid and no response is pending. A first lookup misses and names way 0 as its victim.
- R2: The set is chosen by line address bits [6:0], and the tag compared is bits [26:7]. A matching tag in a different set does not hit.
- R3: Every lookup gives a response in the next cycle carrying hit, hit way and line state. The state is the one found before the access, encoded invalid=0, exclusive=1, modified=2. On a miss the hit way and state read 0.
- R4: A store lookup that hits leaves the line modified.
- R5: A fill for a store installs the line as modified. A read fill with the shared indication low installs it as exclusive. A read fill with the shared indication high installs nothing.
- R6: A hit or an installing fill makes its way the most recently used in that set. A miss leaves the order unchanged.
- R7: On a miss the victim is the lowest-numbered invalid way, or the least recently used way when all four are valid. On a hit the victim field reads 0.
- R8: A miss whose victim is a modified line raises the castout flag in the response.
- R9: A snoop gives a response in the next cycle. A hit on a modified line reports hit with writeback required. A hit on an exclusive line reports hit only. Either way the line becomes invalid, and a snoop miss changes nothing.
- R10: When a snoop and a lookup arrive together for the same line, the snoop acts first. The lookup misses, and a store does not upgrade the line.
- R11: When a lookup hit and a fill touch the same set in one cycle, the fill is applied after the hit, so the filled way ends up most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_line_addr | input | 27 | Lookup line address (physical address bits [31:5]) |
| lk_store | input | 1 | Lookup is a store |
| fill_valid | input | 1 | Fill request |
| fill_line_addr | input | 27 | Line address being filled |
| fill_way | input | 2 | Way to install into |
| fill_store | input | 1 | Fill serves a store; install modified |
| fill_shared | input | 1 | Bus reports another holder of the line |
| snp_valid | input | 1 | Snoop request |
| snp_line_addr | input | 27 | Snooped line address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Hit way |
| rsp_state | output | 2 | State found (0 I, 1 E, 2 M) |
| rsp_victim | output | 2 | Victim way on a miss |
| rsp_castout | output | 1 | Victim is modified and must be written back |
| snp_rsp_valid | output | 1 | Snoop response valid |
| snp_hit | output | 1 | Snoop found the line |
| snp_wb_req | output | 1 | Snooped line was modified; writeback required |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a snoop and a lookup. The bench issues a store lookup and a snoop to the same exclusive line in one cycle. It expects the lookup to miss with the lowest free way as its victim, and the snoop to report a clean hit. A second lookup of that line must then miss, which shows the line was left invalid rather than upgraded.

The second pair is a lookup hit and a fill in one set. The bench fills the remaining ways afterwards and checks which way a later miss names as its victim, with castout. That victim differs depending on whether the fill was ordered after the hit or before it.

// File: rtl/mei_pkg.sv
package mei_pkg;

    // Line coherency states held in the directory
    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_EXC = 2'b01,
        LN_MOD = 2'b10
    } line_st_e;

endpackage

// File: rtl/mei_way_match.sv
module mei_way_match
    import mei_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0][1:0]       way_st,
    input  logic [WAYS-1:0]            way_kill,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic [WAY_W-1:0]           hit_idx
);

    // One comparator per way; a killed or invalid way never matches
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = (way_st[g] != LN_INV) && !way_kill[g]
                            && (way_tag[g] == probe_tag);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) hit_idx = WAY_W'(i);
        end
    end

endmodule

// File: rtl/mei_lru_touch.sv
module mei_lru_touch #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] rank_in,
    input  logic [WAY_W-1:0]           touch_way,
    output logic [WAYS-1:0][WAY_W-1:0] rank_out
);

    // Rank 0 is most recent; ways younger than the touched one age by one
    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            if (WAY_W'(i) == touch_way) begin
                rank_out[i] = '0;
            end else if (rank_in[i] < rank_in[touch_way]) begin
                rank_out[i] = rank_in[i] + WAY_W'(1);
            end else begin
                rank_out[i] = rank_in[i];
            end
        end
    end

endmodule

// File: rtl/mei_victim_pick.sv
module mei_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            line_live,
    input  logic [WAYS-1:0][WAY_W-1:0] rank,
    output logic [WAY_W-1:0]           victim
);

    logic [WAY_W-1:0] lru_way;
    logic [WAY_W-1:0] free_way;
    logic             free_any;

    always_comb begin
        lru_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (rank[i] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(i);
        end
        free_way = '0;
        free_any = 1'b0;
        // Scan downwards so the lowest free way wins
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!line_live[i]) begin
                free_way = WAY_W'(i);
                free_any = 1'b1;
            end
        end
        victim = free_any ? free_way : lru_way;
    end

endmodule

// File: rtl/mei_tag_array.sv
module mei_tag_array
    import mei_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    localparam int OFF_W   = $clog2(LINE_BYTES),
    localparam int IDX_W   = $clog2(SETS),
    localparam int LINE_AW = ADDR_W - OFF_W,
    localparam int TAG_W   = LINE_AW - IDX_W,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [LINE_AW-1:0] lk_line_addr,
    input  logic               lk_store,
    input  logic               fill_valid,
    input  logic [LINE_AW-1:0] fill_line_addr,
    input  logic [WAY_W-1:0]   fill_way,
    input  logic               fill_store,
    input  logic               fill_shared,
    input  logic               snp_valid,
    input  logic [LINE_AW-1:0] snp_line_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [WAY_W-1:0]   rsp_way,
    output logic [1:0]         rsp_state,
    output logic [WAY_W-1:0]   rsp_victim,
    output logic               rsp_castout,
    output logic               snp_rsp_valid,
    output logic               snp_hit,
    output logic               snp_wb_req
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0][1:0]       st;
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] rank;
        logic                                 rsp_valid;
        logic                                 rsp_hit;
        logic [WAY_W-1:0]                     rsp_way;
        logic [1:0]                           rsp_state;
        logic [WAY_W-1:0]                     rsp_victim;
        logic                                 rsp_castout;
        logic                                 snp_rsp_valid;
        logic                                 snp_hit;
        logic                                 snp_wb_req;
    } dir_state_t;

    dir_state_t s_d, s_q;

    // Address fields
    logic [IDX_W-1:0] lk_idx, sn_idx, fl_idx;
    logic [TAG_W-1:0] lk_tag, sn_tag, fl_tag;

    assign lk_idx = lk_line_addr[IDX_W-1:0];
    assign lk_tag = lk_line_addr[LINE_AW-1:IDX_W];
    assign sn_idx = snp_line_addr[IDX_W-1:0];
    assign sn_tag = snp_line_addr[LINE_AW-1:IDX_W];
    assign fl_idx = fill_line_addr[IDX_W-1:0];
    assign fl_tag = fill_line_addr[LINE_AW-1:IDX_W];

    // Snoop probe
    logic [WAYS-1:0]  sn_hv;
    logic [WAY_W-1:0] sn_hw;
    logic             sn_any;

    mei_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_snp_match (
        .way_tag   (s_q.tag[sn_idx]),
        .way_st    (s_q.st[sn_idx]),
        .way_kill  ('0),
        .probe_tag (sn_tag),
        .hit_vec   (sn_hv),
        .hit_idx   (sn_hw)
    );

    assign sn_any = snp_valid && (|sn_hv);

    // Lookup probe; a same-cycle snoop in the same set is ordered first
    logic [WAYS-1:0]  lk_kill;
    logic [WAYS-1:0]  lk_hv;
    logic [WAY_W-1:0] lk_hw;
    logic             lk_hit;
    logic [WAYS-1:0]  lk_live;

    assign lk_kill = (snp_valid && (sn_idx == lk_idx)) ? sn_hv : '0;

    mei_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .way_tag   (s_q.tag[lk_idx]),
        .way_st    (s_q.st[lk_idx]),
        .way_kill  (lk_kill),
        .probe_tag (lk_tag),
        .hit_vec   (lk_hv),
        .hit_idx   (lk_hw)
    );

    assign lk_hit = |lk_hv;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_live[w] = (s_q.st[lk_idx][w] != LN_INV) && !lk_kill[w];
        end
    end

    // Victim selection
    logic [WAY_W-1:0] vic_way;
    logic             vic_dirty;

    mei_victim_pick #(.WAYS(WAYS)) u_victim (
        .line_live (lk_live),
        .rank      (s_q.rank[lk_idx]),
        .victim    (vic_way)
    );

    assign vic_dirty = lk_live[vic_way] && (s_q.st[lk_idx][vic_way] == LN_MOD);

    // Replacement order: the lookup hit first, then the fill
    logic                         fl_install;
    logic [WAYS-1:0][WAY_W-1:0]   lk_rank_new;
    logic [WAYS-1:0][WAY_W-1:0]   fl_rank_base;
    logic [WAYS-1:0][WAY_W-1:0]   fl_rank_new;

    assign fl_install = fill_valid && (fill_store || !fill_shared);

    mei_lru_touch #(.WAYS(WAYS)) u_lk_touch (
        .rank_in   (s_q.rank[lk_idx]),
        .touch_way (lk_hw),
        .rank_out  (lk_rank_new)
    );

    assign fl_rank_base = (lk_valid && lk_hit && (lk_idx == fl_idx))
                          ? lk_rank_new : s_q.rank[fl_idx];

    mei_lru_touch #(.WAYS(WAYS)) u_fl_touch (
        .rank_in   (fl_rank_base),
        .touch_way (fill_way),
        .rank_out  (fl_rank_new)
    );

    // Next-state computation
    always_comb begin
        s_d = s_q;

        if (snp_valid) begin
            for (int w = 0; w < WAYS; w++) begin
                if (sn_hv[w]) s_d.st[sn_idx][w] = LN_INV;
            end
        end

        if (lk_valid && lk_hit) begin
            s_d.rank[lk_idx] = lk_rank_new;
            if (lk_store) s_d.st[lk_idx][lk_hw] = LN_MOD;
        end

        if (fl_install) begin
            s_d.tag[fl_idx][fill_way] = fl_tag;
            s_d.st[fl_idx][fill_way]  = fill_store ? LN_MOD : LN_EXC;
            s_d.rank[fl_idx]          = fl_rank_new;
        end

        s_d.rsp_valid   = lk_valid;
        s_d.rsp_hit     = lk_valid && lk_hit;
        s_d.rsp_way     = (lk_valid && lk_hit) ? lk_hw : '0;
        s_d.rsp_state   = (lk_valid && lk_hit) ? s_q.st[lk_idx][lk_hw] : LN_INV;
        s_d.rsp_victim  = (lk_valid && !lk_hit) ? vic_way : '0;
        s_d.rsp_castout = lk_valid && !lk_hit && vic_dirty;

        s_d.snp_rsp_valid = snp_valid;
        s_d.snp_hit       = sn_any;
        s_d.snp_wb_req    = sn_any && (s_q.st[sn_idx][sn_hw] == LN_MOD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    s_q.rank[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid     = s_q.rsp_valid;
    assign rsp_hit       = s_q.rsp_hit;
    assign rsp_way       = s_q.rsp_way;
    assign rsp_state     = s_q.rsp_state;
    assign rsp_victim    = s_q.rsp_victim;
    assign rsp_castout   = s_q.rsp_castout;
    assign snp_rsp_valid = s_q.snp_rsp_valid;
    assign snp_hit       = s_q.snp_hit;
    assign snp_wb_req    = s_q.snp_wb_req;

    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R8
    castout_only_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_castout |-> (rsp_valid && !rsp_hit));

    // R9
    wb_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_wb_req |-> (snp_rsp_valid && snp_hit));

    // R7
    free_way_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit && !(&lk_live)) |-> !lk_live[vic_way]);

    // R10
    snoop_before_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && snp_valid && (sn_idx == lk_idx) && (sn_tag == lk_tag) && (|sn_hv))
        |-> !lk_hit);

    // R4
    store_hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_hit && lk_store
         && !(fl_install && (fl_idx == lk_idx) && (fill_way == lk_hw)))
        |=> (s_q.st[$past(lk_idx)][$past(lk_hw)] == LN_MOD));

    // R6
    hit_becomes_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_hit && !(fl_install && (fl_idx == lk_idx)))
        |=> (s_q.rank[$past(lk_idx)][$past(lk_hw)] == '0));

    // R9
    snoop_invalidates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_any && !(fl_install && (fl_idx == sn_idx) && (fill_way == sn_hw)))
        |=> (s_q.st[$past(sn_idx)][$past(sn_hw)] == LN_INV));

endmodule

// File: tb/tb_mei_tag_array.sv
`timescale 1ns/1ps
module tb_mei_tag_array;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [26:0] lk_line_addr = '0;
    logic        lk_store = 1'b0;
    logic        fill_valid = 1'b0;
    logic [26:0] fill_line_addr = '0;
    logic [1:0]  fill_way = '0;
    logic        fill_store = 1'b0;
    logic        fill_shared = 1'b0;
    logic        snp_valid = 1'b0;
    logic [26:0] snp_line_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_castout;
    logic [1:0]  rsp_way, rsp_state, rsp_victim;
    logic        snp_rsp_valid, snp_hit, snp_wb_req;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic       hit;
        logic [1:0] way;
        logic [1:0] st;
        logic [1:0] vic;
        logic       co;
        string      req;
    } lk_exp_t;

    typedef struct {
        logic  hit;
        logic  wb;
        string req;
    } sn_exp_t;

    lk_exp_t lk_q[$];
    sn_exp_t sn_q[$];

    always #2.5 clk = ~clk;

    mei_tag_array dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_line_addr(lk_line_addr), .lk_store(lk_store),
        .fill_valid(fill_valid), .fill_line_addr(fill_line_addr), .fill_way(fill_way),
        .fill_store(fill_store), .fill_shared(fill_shared),
        .snp_valid(snp_valid), .snp_line_addr(snp_line_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_state(rsp_state), .rsp_victim(rsp_victim), .rsp_castout(rsp_castout),
        .snp_rsp_valid(snp_rsp_valid), .snp_hit(snp_hit), .snp_wb_req(snp_wb_req)
    );

    // Driver tasks: set inputs at a falling edge and queue the expected result
    task automatic look(input logic [19:0] t, input logic [6:0] ix, input logic st,
                        input logic eh, input logic [1:0] ew, input logic [1:0] es,
                        input logic [1:0] ev, input logic ec, input string rq);
        lk_exp_t e;
        lk_valid = 1'b1;
        lk_line_addr = {t, ix};
        lk_store = st;
        e.hit = eh; e.way = ew; e.st = es; e.vic = ev; e.co = ec; e.req = rq;
        lk_q.push_back(e);
    endtask

    task automatic fill(input logic [19:0] t, input logic [6:0] ix, input logic [1:0] w,
                        input logic st, input logic sh);
        fill_valid = 1'b1;
        fill_line_addr = {t, ix};
        fill_way = w;
        fill_store = st;
        fill_shared = sh;
    endtask

    task automatic snoop(input logic [19:0] t, input logic [6:0] ix,
                         input logic eh, input logic ewb, input string rq);
        sn_exp_t e;
        snp_valid = 1'b1;
        snp_line_addr = {t, ix};
        e.hit = eh; e.wb = ewb; e.req = rq;
        sn_q.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
        lk_valid = 1'b0;
        lk_store = 1'b0;
        fill_valid = 1'b0;
        fill_store = 1'b0;
        fill_shared = 1'b0;
        snp_valid = 1'b0;
    endtask

    // Monitor: compares responses just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && rsp_valid) begin
                n_chk++;
                if (lk_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R3: unexpected lookup response, got valid=1 expected valid=0");
                end else begin
                    lk_exp_t e;
                    e = lk_q.pop_front();
                    if (rsp_hit !== e.hit || rsp_way !== e.way || rsp_state !== e.st ||
                        rsp_victim !== e.vic || rsp_castout !== e.co) begin
                        n_fail++;
                        $display("FAIL %s: got hit=%0d way=%0d st=%0d vic=%0d co=%0d expected hit=%0d way=%0d st=%0d vic=%0d co=%0d",
                                 e.req, rsp_hit, rsp_way, rsp_state, rsp_victim, rsp_castout,
                                 e.hit, e.way, e.st, e.vic, e.co);
                    end
                end
            end
            if (rst_n && snp_rsp_valid) begin
                n_chk++;
                if (sn_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9: unexpected snoop response, got valid=1 expected valid=0");
                end else begin
                    sn_exp_t e;
                    e = sn_q.pop_front();
                    if (snp_hit !== e.hit || snp_wb_req !== e.wb) begin
                        n_fail++;
                        $display("FAIL %s: got snp_hit=%0d wb=%0d expected snp_hit=%0d wb=%0d",
                                 e.req, snp_hit, snp_wb_req, e.hit, e.wb);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got run still active expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: nothing pending after reset
        n_chk++;
        if (rsp_valid !== 1'b0 || snp_rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got rsp_valid=%0d snp_rsp_valid=%0d expected 0 0",
                     rsp_valid, snp_rsp_valid);
        end

        look(20'd1, 7'd5, 0, 0, 0, 0, 0, 0, "R1"); step();
        fill(20'd1, 7'd5, 2'd0, 0, 0); step();
        look(20'd1, 7'd5, 0, 1, 0, 1, 0, 0, "R2"); step();
        look(20'd1, 7'd6, 0, 0, 0, 0, 0, 0, "R2"); step();
        look(20'd2, 7'd5, 0, 0, 0, 0, 1, 0, "R7"); step();
        fill(20'd2, 7'd5, 2'd1, 1, 0); step();
        look(20'd3, 7'd5, 0, 0, 0, 0, 2, 0, "R7"); step();
        fill(20'd3, 7'd5, 2'd2, 0, 1); step();
        look(20'd3, 7'd5, 0, 0, 0, 0, 2, 0, "R5"); step();
        look(20'd2, 7'd5, 0, 1, 1, 2, 0, 0, "R5"); step();
        fill(20'd3, 7'd5, 2'd2, 0, 0); step();
        fill(20'd4, 7'd5, 2'd3, 0, 0); step();
        look(20'd5, 7'd5, 0, 0, 0, 0, 0, 0, "R7"); step();
        look(20'd1, 7'd5, 0, 1, 0, 1, 0, 0, "R6"); step();
        look(20'd5, 7'd5, 0, 0, 0, 0, 1, 1, "R8"); step();
        look(20'd1, 7'd5, 1, 1, 0, 1, 0, 0, "R4"); step();
        look(20'd1, 7'd5, 0, 1, 0, 2, 0, 0, "R4"); step();
        snoop(20'd2, 7'd5, 1, 1, "R9"); step();
        look(20'd2, 7'd5, 0, 0, 0, 0, 1, 0, "R9"); step();
        snoop(20'd4, 7'd5, 1, 0, "R9"); step();
        look(20'd4, 7'd5, 0, 0, 0, 0, 1, 0, "R9"); step();
        snoop(20'd5, 7'd5, 0, 0, "R9"); step();
        look(20'd3, 7'd5, 0, 1, 2, 1, 0, 0, "R9"); step();
        // R10: snoop and store lookup to the same line together
        look(20'd3, 7'd5, 1, 0, 0, 0, 1, 0, "R10");
        snoop(20'd3, 7'd5, 1, 0, "R10"); step();
        look(20'd3, 7'd5, 0, 0, 0, 0, 1, 0, "R10"); step();
        // R11: lookup hit and fill in the same set together
        look(20'd1, 7'd5, 0, 1, 0, 2, 0, 0, "R11");
        fill(20'd6, 7'd5, 2'd1, 0, 0); step();
        fill(20'd7, 7'd5, 2'd2, 0, 0); step();
        fill(20'd8, 7'd5, 2'd3, 0, 0); step();
        look(20'd9, 7'd5, 0, 0, 0, 0, 0, 1, "R11"); step();

        step();
        step();
        n_chk++;
        if (lk_q.size() != 0 || sn_q.size() != 0) begin
            n_fail++;
            $display("FAIL R3: got %0d lookup and %0d snoop responses missing expected 0 0",
                     lk_q.size(), sn_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule